// File: doc/BRIEF.md
# Port Flush Table Walker

This block clears forwarding state that belongs to a chosen set of switch ports. It is started with a port mask. It then walks every index of the forwarding table in ascending order and, for each index, reads the entry and inspects its type. Entries that hold an address are edited and written back. Entries of any other type are left alone.

A unicast address entry names a single port. The entry is freed when that port is part of the flush mask. A multicast address entry carries a port mask, and only the flushed ports are removed from it. When the host port is the only one left, the multicast entry is freed instead. The host port's bit position equals the configured number of ports. The table is an external single-port memory with a one-cycle read latency. Each entry takes two cycles: one to read it and one to edit it and write it back. A one-cycle `done` pulse marks the end of the walk.

Top module: `port_flush_walker`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `tbl_rd_en` and `tbl_wr_en` are low until `start` is seen.
- R2: A `start` sampled while idle begins a walk. The walk issues exactly one read per index, from 0 up to DEPTH-1, with each read two cycles after the previous one. A read and a write never share a cycle.
- R3: An entry whose type field (bits 61:60) is 0 or 2 is never written.
- R4: Every entry of type 1 or 3 is written back to its own index in the cycle after its read, even when its content is unchanged.
- R5: Bit 40 of an address entry selects multicast (1) or unicast (0). A write changes no bits other than the type field (61:60) and the port field (68:66).
- R6: A multicast entry whose port mask (bits 68:66) shares no bit with the flush mask is written back unchanged.
- R7: For a multicast entry that does share a bit, the flushed bits are cleared from its mask. If the remainder equals only bit `num_ports`, the type field is set to 0 instead and the mask is kept as it was.
- R8: A unicast entry whose port number (bits 67:66) has its bit set in the flush mask gets type 0. Otherwise it is written back unchanged.
- R9: With a flush mask of zero, the walk writes every address entry back unchanged.
- R10: `done` is high for exactly one cycle, 2*DEPTH+1 cycles after the cycle in which `start` was sampled. `busy` is low in that cycle.
- R11: A `start` during a walk or in its `done` cycle is ignored. The walk keeps its index and keeps the flush mask and port count that were captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| flush_mask | input | MASK_W | Ports to flush, bit n = port n |
| num_ports | input | NP_W | Port count; selects the host-port bit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| tbl_addr | output | IDX_W | Table index for read or write |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_data | input | ENTRY_W | Read data, valid the cycle after `tbl_rd_en` |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_data | output | ENTRY_W | Entry to write |

## Verification
The assertions assume a table that returns read data exactly one cycle after `tbl_rd_en` and that nothing else writes the table during a walk. They also assume `num_ports` is below MASK_W and that every unicast port number addresses a bit inside the flush mask. The stimulus loads the table only while the walker is idle. It keeps `num_ports` at 1 or 2 and remaps a unicast port number of 3 to 2. It then changes `start` and `flush_mask` in the middle of a walk to confirm that the captured values are the ones used.

// File: rtl/flush_walk_pkg.sv
// Package: shared entry-layout constants, type codes and walker state type.
// Assumes the table entry layout fixed by the neighbouring lookup logic.
package flush_walk_pkg;

    localparam int TYPE_LSB     = 60;  // two-bit entry type
    localparam int MC_BIT       = 40;  // multicast flag of address entries
    localparam int PORT_FLD_LSB = 66;  // port number / port mask base

    localparam logic [1:0] ET_FREE  = 2'd0;
    localparam logic [1:0] ET_ADDR  = 2'd1;
    localparam logic [1:0] ET_VLAN  = 2'd2;
    localparam logic [1:0] ET_VADDR = 2'd3;

    typedef enum logic [1:0] {
        W_IDLE,
        W_READ,
        W_EDIT,
        W_DONE
    } walk_state_t;

endpackage

// File: rtl/flush_walk_ctrl.sv
// Module: walk sequencer. Steps an index from 0 to DEPTH-1, spending one
// cycle reading and one cycle editing each entry, then pulses done.
// Assumes the table answers a read one cycle later.
module flush_walk_ctrl
    import flush_walk_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic             edit_en,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    walk_state_t      state_q;
    logic [IDX_W-1:0] idx_q;

    // Walk state and index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (start) begin
                        state_q <= W_READ;
                        idx_q   <= '0;
                    end
                end
                W_READ: state_q <= W_EDIT;
                W_EDIT: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= W_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= W_READ;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    // Decode of the state into strobes.
    always_comb begin
        rd_en   = (state_q == W_READ);
        edit_en = (state_q == W_EDIT);
        busy    = rd_en || edit_en;
        done    = (state_q == W_DONE);
        idx     = idx_q;
    end

    // Each edit cycle follows its read cycle.
    p_edit_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edit_en |-> $past(rd_en));

    // Reads advance the index by exactly one.
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx != '0) |-> (idx == $past(idx, 2) + 1'b1));

    // done is a single-cycle pulse with busy low.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // start in the middle of a walk does not end it.
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(edit_en && idx == LAST_IDX)) |=> busy);

endmodule

// File: rtl/flush_entry_edit.sv
// Module: combinational entry editor. Applies the flush rules to one
// entry: non-address entries pass through, unicast entries are freed when
// their port is flushed, and multicast entries lose the flushed ports and
// are freed when only the host port remains.
// Assumes host_sel < MASK_W.
module flush_entry_edit
    import flush_walk_pkg::*;
#(
    parameter int ENTRY_W = 72,
    parameter int MASK_W  = 3,
    parameter int NP_W    = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
    input  logic [ENTRY_W-1:0] entry_in,
    input  logic [MASK_W-1:0]  flush_mask,
    input  logic [NP_W-1:0]    host_sel,
    output logic [ENTRY_W-1:0] entry_out,
    output logic               is_addr
);

    logic [1:0]        etype;
    logic              is_mc;
    logic [MASK_W-1:0] pmask;
    logic [NP_W-1:0]   pnum;
    logic [MASK_W-1:0] host_bit;
    logic [MASK_W-1:0] uc_bit;
    logic [MASK_W-1:0] mc_rem;
    logic              mc_hit;
    logic              uc_hit;

    // Field extraction and overlap terms.
    always_comb begin
        etype    = entry_in[TYPE_LSB +: 2];
        is_mc    = entry_in[MC_BIT];
        pmask    = entry_in[PORT_FLD_LSB +: MASK_W];
        pnum     = entry_in[PORT_FLD_LSB +: NP_W];
        host_bit = MASK_W'(1) << host_sel;
        uc_bit   = MASK_W'(1) << pnum;
        mc_rem   = pmask & ~flush_mask;
        mc_hit   = |(pmask & flush_mask);
        uc_hit   = |(uc_bit & flush_mask);
        is_addr  = (etype == ET_ADDR) || (etype == ET_VADDR);
    end

    // Rewrite of the type or port field according to the flush rules.
    always_comb begin
        entry_out = entry_in;
        if (is_addr) begin
            if (is_mc) begin
                if (mc_hit) begin
                    if (mc_rem == host_bit) begin
                        entry_out[TYPE_LSB +: 2] = ET_FREE;
                    end else begin
                        entry_out[PORT_FLD_LSB +: MASK_W] = mc_rem;
                    end
                end
            end else if (uc_hit) begin
                entry_out[TYPE_LSB +: 2] = ET_FREE;
            end
        end
    end

endmodule

// File: rtl/port_flush_walker.sv
// Module: top of the port flush walker. Captures the flush mask and port
// count at start, sequences the walk and drives the table port with the
// edited entries.
// Assumes a single-port table with one-cycle read latency, owned by this
// block for the length of a walk.
module port_flush_walker
    import flush_walk_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int MASK_W  = 3,
    parameter int ENTRY_W = 72,
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int NP_W    = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MASK_W-1:0]  flush_mask,
    input  logic [NP_W-1:0]    num_ports,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   tbl_addr,
    output logic               tbl_rd_en,
    input  logic [ENTRY_W-1:0] tbl_rd_data,
    output logic               tbl_wr_en,
    output logic [ENTRY_W-1:0] tbl_wr_data
);

    localparam logic [ENTRY_W-1:0] EDIT_FIELDS =
        ({{(ENTRY_W-MASK_W){1'b0}}, {MASK_W{1'b1}}} << PORT_FLD_LSB) |
        ({{(ENTRY_W-2){1'b0}}, 2'b11} << TYPE_LSB);

    logic [MASK_W-1:0] cfg_mask_q;
    logic [NP_W-1:0]   cfg_np_q;
    logic              edit_en;
    logic              is_addr;
    logic [IDX_W-1:0]  idx;
    logic [ENTRY_W-1:0] edited;

    // Capture of the walk configuration when a walk is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mask_q <= '0;
            cfg_np_q   <= '0;
        end else if (start && !busy && !done) begin
            cfg_mask_q <= flush_mask;
            cfg_np_q   <= num_ports;
        end
    end

    flush_walk_ctrl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .rd_en   (tbl_rd_en),
        .edit_en (edit_en),
        .idx     (idx)
    );

    flush_entry_edit #(
        .ENTRY_W (ENTRY_W),
        .MASK_W  (MASK_W),
        .NP_W    (NP_W)
    ) edit_i (
        .entry_in   (tbl_rd_data),
        .flush_mask (cfg_mask_q),
        .host_sel   (cfg_np_q),
        .entry_out  (edited),
        .is_addr    (is_addr)
    );

    // Table port drive: write only address entries in the edit cycle.
    always_comb begin
        tbl_addr    = idx;
        tbl_wr_en   = edit_en && is_addr;
        tbl_wr_data = edited;
    end

    // Write lands on the index read in the previous cycle.
    p_wr_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> ($past(tbl_rd_en) && tbl_addr == $past(tbl_addr)));

    // Only address-type entries are written.
    p_wr_addr_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> (tbl_rd_data[TYPE_LSB +: 2] == ET_ADDR ||
                       tbl_rd_data[TYPE_LSB +: 2] == ET_VADDR));

    // Bits outside the type and port fields survive the edit.
    p_other_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> ((tbl_wr_data & ~EDIT_FIELDS) == (tbl_rd_data & ~EDIT_FIELDS)));

    // An empty flush mask writes entries back unchanged.
    p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en && cfg_mask_q == '0) |-> (tbl_wr_data == tbl_rd_data));

    // Read and write never share a cycle.
    p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_rd_en && tbl_wr_en));

    // Outputs quiet while reset is applied.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && !tbl_rd_en && !tbl_wr_en));

endmodule

// File: tb/port_flush_walker_tb_top.sv
module port_flush_walker_tb_top;

    localparam int DEPTH   = 64;
    localparam int MASK_W  = 3;
    localparam int ENTRY_W = 72;
    localparam int IDX_W   = 6;
    localparam int NP_W    = 2;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [ENTRY_W-1:0] data;
    } wr_item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [MASK_W-1:0]  flush_mask = '0;
    logic [NP_W-1:0]    num_ports = 2'd2;
    logic               busy, done, tbl_rd_en, tbl_wr_en;
    logic [IDX_W-1:0]   tbl_addr;
    logic [ENTRY_W-1:0] tbl_rd_data, tbl_wr_data;

    logic               ld_en = 1'b0;
    logic [IDX_W-1:0]   ld_addr = '0;
    logic [ENTRY_W-1:0] ld_data = '0;
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] model [DEPTH];

    wr_item_t exp_q [$];
    int drv_total = 0, drv_bad = 0;
    int mon_total = 0, mon_bad = 0;
    int rd_next = 0;

    always #2.5 clk = ~clk;

    port_flush_walker #(
        .DEPTH (DEPTH), .MASK_W (MASK_W), .ENTRY_W (ENTRY_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start),
        .flush_mask (flush_mask), .num_ports (num_ports),
        .busy (busy), .done (done), .tbl_addr (tbl_addr),
        .tbl_rd_en (tbl_rd_en), .tbl_rd_data (tbl_rd_data),
        .tbl_wr_en (tbl_wr_en), .tbl_wr_data (tbl_wr_data)
    );

    // Table model: one-cycle read latency, bench load port has priority.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (tbl_wr_en) mem[tbl_addr] <= tbl_wr_data;
        if (tbl_rd_en) tbl_rd_data <= mem[tbl_addr];
    end

    // Expected entry after a flush, from the requirements.
    function automatic logic [ENTRY_W-1:0] flush_ref(logic [ENTRY_W-1:0] e,
            logic [MASK_W-1:0] fm, logic [NP_W-1:0] np);
        logic [ENTRY_W-1:0] r;
        logic [MASK_W-1:0]  m, rem;
        r = e;
        if (e[61:60] == 2'd1 || e[61:60] == 2'd3) begin
            if (e[40]) begin
                m = e[68:66];
                if ((m & fm) != '0) begin
                    rem = m & ~fm;
                    if (rem == (MASK_W'(1) << np)) r[61:60] = 2'd0;
                    else r[68:66] = rem;
                end
            end else if (fm[e[67:66]]) begin
                r[61:60] = 2'd0;
            end
        end
        return r;
    endfunction

    // Varied table content covering all types, masks and ports.
    function automatic logic [ENTRY_W-1:0] make_entry(int i, int salt);
        logic [ENTRY_W-1:0] e;
        e = {8'(i * 37 + salt), 64'(64'(i + 1) * 64'h9E3779B97F4A7C15 ^ 64'(salt))};
        e[61:60] = 2'(i) ^ 2'(salt);
        e[40]    = i[2];
        e[68:66] = 3'(i >> 3) ^ 3'(salt);
        if (!e[40] && e[67:66] == 2'd3) e[67:66] = 2'd2;
        return e;
    endfunction

    task automatic dcheck(bit ok, string req, logic [ENTRY_W-1:0] got,
                          logic [ENTRY_W-1:0] exp);
        drv_total++;
        if (!ok) begin
            drv_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: read order and scoreboard of writes.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_next = 0;
        end else begin
            if (done) rd_next = 0;
            if (tbl_rd_en) begin
                mon_total++;
                if (int'(tbl_addr) != rd_next) begin
                    mon_bad++;
                    $display("FAIL R2/R11 read order: got %0d expected %0d", tbl_addr, rd_next);
                end
                rd_next++;
            end
            if (tbl_wr_en) begin
                mon_total++;
                if (exp_q.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R3 unexpected write: got idx %0d expected none", tbl_addr);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    if (it.idx != tbl_addr || it.data != tbl_wr_data) begin
                        mon_bad++;
                        $display("FAIL R4 R6 R7 R8 write: got %0d:%h expected %0d:%h",
                                 tbl_addr, tbl_wr_data, it.idx, it.data);
                    end
                end
            end
        end
    end

    // Driver: load the table, queue expected writes, run a walk, check end.
    task automatic run_walk(int salt, logic [MASK_W-1:0] fm, logic [NP_W-1:0] np,
                            bit inject, string tag);
        int cnt;
        int mism;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = IDX_W'(i); ld_data = make_entry(i, salt);
            model[i] = make_entry(i, salt);
        end
        @(negedge clk);
        ld_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (model[i][61:60] == 2'd1 || model[i][61:60] == 2'd3) begin
                model[i] = flush_ref(model[i], fm, np);
                exp_q.push_back('{idx: IDX_W'(i), data: model[i]});
            end
        end
        flush_mask = fm; num_ports = np; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 4 * DEPTH) begin
            if (inject && (cnt == 20 || cnt == 2 * DEPTH)) begin
                start = 1'b1; flush_mask = 3'b111; num_ports = 2'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        dcheck(cnt == 2 * DEPTH + 1, {"R10 done timing ", tag}, ENTRY_W'(cnt), ENTRY_W'(2 * DEPTH + 1));
        dcheck(!busy, {"R10 busy low at done ", tag}, ENTRY_W'(busy), '0);
        @(negedge clk);
        dcheck(!done, {"R10 done single pulse ", tag}, ENTRY_W'(done), '0);
        dcheck(exp_q.size() == 0, {"R4 all address entries written ", tag},
               ENTRY_W'(exp_q.size()), '0);
        exp_q.delete();
        mism = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mem[i] !== model[i]) begin
                mism++;
                $display("FAIL R3 R5 R6 R7 R8 table idx %0d %s: got %h expected %h",
                         i, tag, mem[i], model[i]);
            end
        end
        drv_total++;
        if (mism != 0) drv_bad++;
        repeat (3) @(negedge clk);
        dcheck(!busy && !done, {"R11 idle after walk ", tag}, ENTRY_W'({busy, done}), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        dcheck(!busy && !done && !tbl_rd_en && !tbl_wr_en, "R1 reset state",
               ENTRY_W'({busy, done, tbl_rd_en, tbl_wr_en}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        dcheck(!busy && !done && !tbl_rd_en && !tbl_wr_en, "R1 idle after reset",
               ENTRY_W'({busy, done, tbl_rd_en, tbl_wr_en}), '0);
        run_walk(0, 3'b010, 2'd2, 1'b0, "R2 R5 single port");
        run_walk(5, 3'b000, 2'd2, 1'b0, "R9 zero mask");
        run_walk(9, 3'b011, 2'd2, 1'b0, "R7 host remainder");
        run_walk(3, 3'b101, 2'd1, 1'b0, "R7 R8 host bit 1");
        run_walk(6, 3'b100, 2'd2, 1'b0, "R8 host flushed");
        run_walk(7, 3'b001, 2'd2, 1'b1, "R11 start ignored");
        $display("  test done: total=%0d bad=%0d", drv_total + mon_total, drv_bad + mon_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", drv_total + mon_total + 1, drv_bad + mon_bad + 1);
        $finish;
    end

endmodule